// File: doc/BRIEF.md
# Two-Crossing Status Double Buffer

This block keeps a small record of trigger status for the last two bunch crossings. Each crossing produces an 8-bit status word. The word holds one enable bit and one AND-OR fired bit for each of four trigger channels.

There are two independent halves, A and B. Each half is a two-stage pipeline. One stage holds the current crossing and the other holds the previous crossing. The block runs on a system clock and watches a latch/shift strobe. On each rising edge of that strobe, the half chosen by the write-select line does two things:

- its current stage moves into its previous stage;
- the live status word is stored as the new current stage.

A read-select line and a stage-select line choose, combinationally, which half and which stage drive the read bus. The stage-select line comes from the address bit of weight 128 in the bus address. When that bit is set, the current crossing is read. When it is clear, the previous crossing is read. The rest of the address decoding is outside this block.

Top module: `status_dbuf`

## Requirements
- R1: The status word puts channel k's enable bit (k = 1..4) at bit k-1 and channel k's AND-OR fired bit at bit k+3. Bit 0 is the least significant bit.
- R2: At a capture, `wr_sel_a` = 1 loads half A and `wr_sel_a` = 0 loads half B. The other half keeps both of its stages unchanged.
- R3: A capture happens only on the first clock at which `shift_in` is sampled high after being sampled low. While it stays high, or stays low, no stage changes, whatever the data inputs do.
- R4: At a capture, the loaded half's previous stage takes the value its current stage held before the capture. Its current stage takes the live status word.
- R5: `rd_sel_a` = 1 reads half A and `rd_sel_a` = 0 reads half B.
- R6: `rd_cur` = 1 reads the current stage of the selected half and `rd_cur` = 0 reads its previous stage.
- R7: While `rst_n` is low, all four stages are zero. The first rising strobe after reset release is treated as a capture edge.
- R8: The read bus follows the two read selects within the same cycle and has no effect on stored state. A captured value is visible on the read bus from the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_in | input | 1 | Latch/shift strobe; its rising edge causes a capture |
| wr_sel_a | input | 1 | 1 loads half A, 0 loads half B |
| rd_sel_a | input | 1 | 1 reads half A, 0 reads half B |
| rd_cur | input | 1 | 1 reads the current stage, 0 reads the previous stage |
| chan_en | input | CH (4) | Per-channel enable state, channel 1 in bit 0 |
| chan_fired | input | CH (4) | Per-channel AND-OR fired state, channel 1 in bit 0 |
| rd_data | output | 2*CH (8) | Selected status word |

## Verification
The assertions check on every cycle that nothing changes without a capture edge. They also check that a capture shifts the loaded half correctly, that the unloaded half is left alone, and that a capture never happens in two cycles in a row. Some behaviour only the bench scenarios can show:

- the bit placement of each channel in the status word;
- the mapping of every read-select and stage-select combination to the stored words;
- that a strobe held high across changing data records only the first word;
- that reset in mid-run clears both halves.

// File: rtl/status_dbuf.sv
module status_dbuf #(
  parameter int CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_in,
  input  logic            wr_sel_a,
  input  logic            rd_sel_a,
  input  logic            rd_cur,
  input  logic [CH-1:0]   chan_en,
  input  logic [CH-1:0]   chan_fired,
  output logic [2*CH-1:0] rd_data
);
  localparam int W = 2 * CH;
  localparam int HALVES = 2;

  logic shift_q;
  logic cap;
  logic [W-1:0] word_in;
  logic [HALVES-1:0][W-1:0] cur_w;
  logic [HALVES-1:0][W-1:0] prev_w;

  assign word_in = {chan_fired, chan_en};
  assign cap = shift_in & ~shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= 1'b0;
    else        shift_q <= shift_in;
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic sel;
    logic [W-1:0] cur_q, prev_q;
    assign sel = (h == 0) ? wr_sel_a : ~wr_sel_a;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else if (cap && sel) begin
        prev_q <= cur_q;
        cur_q  <= word_in;
      end
    end

    assign cur_w[h]  = cur_q;
    assign prev_w[h] = prev_q;
  end

  logic rh;
  assign rh = ~rd_sel_a;
  assign rd_data = rd_cur ? cur_w[rh] : prev_w[rh];

  logic [W-1:0] a_cur, a_prev, b_cur, b_prev;
  assign a_cur  = cur_w[0];
  assign a_prev = prev_w[0];
  assign b_cur  = cur_w[1];
  assign b_prev = prev_w[1];
endmodule

module status_dbuf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap,
  input logic         wr_sel_a,
  input logic [W-1:0] word_in,
  input logic [W-1:0] a_cur,
  input logic [W-1:0] a_prev,
  input logic [W-1:0] b_cur,
  input logic [W-1:0] b_prev
);
  // R3
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(a_cur) && $stable(a_prev) && $stable(b_cur) && $stable(b_prev)));

  // R3
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap);

  // R4
  a_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && wr_sel_a) |=> (a_prev == $past(a_cur) && a_cur == $past(word_in)));

  // R4
  b_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !wr_sel_a) |=> (b_prev == $past(b_cur) && b_cur == $past(word_in)));

  // R2
  a_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !wr_sel_a) |=> ($stable(a_cur) && $stable(a_prev)));

  // R2
  b_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && wr_sel_a) |=> ($stable(b_cur) && $stable(b_prev)));
endmodule

bind status_dbuf status_dbuf_chk #(.W(2*CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap(cap), .wr_sel_a(wr_sel_a), .word_in(word_in),
  .a_cur(a_cur), .a_prev(a_prev), .b_cur(b_cur), .b_prev(b_prev)
);

// File: tb/status_dbuf_tb.sv
`timescale 1ns/1ps
module status_dbuf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_in = 1'b0, wr_sel_a = 1'b0, rd_sel_a = 1'b0, rd_cur = 1'b0;
  logic [3:0] chan_en = '0, chan_fired = '0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  status_dbuf u_dut (.*);

  // behavioural reference: index 0 = half A, 1 = half B
  logic [7:0] m_cur [2];
  logic [7:0] m_prev [2];
  logic m_shq = 1'b0;
  initial begin m_cur = '{8'h0, 8'h0}; m_prev = '{8'h0, 8'h0}; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur[0] <= 8'h0; m_cur[1] <= 8'h0; m_prev[0] <= 8'h0; m_prev[1] <= 8'h0;
      m_shq <= 1'b0;
    end else begin
      if (shift_in && !m_shq) begin
        int h;
        h = wr_sel_a ? 0 : 1;
        m_prev[h] <= m_cur[h];
        m_cur[h]  <= {chan_fired, chan_en};
      end
      m_shq <= shift_in;
    end
  end

  function automatic logic [7:0] model_read(logic sa, logic cur);
    int h;
    h = sa ? 0 : 1;
    return cur ? m_cur[h] : m_prev[h];
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // R8 per-cycle comparison with the reference model
  always begin
    @(negedge clk); #2;
    if (!done) check("R8", rd_data, model_read(rd_sel_a, rd_cur));
  end

  task automatic rd(string tag, logic sa, logic cur, logic [7:0] exp);
    @(negedge clk);
    rd_sel_a = sa; rd_cur = cur;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic pulse(logic wa, logic [3:0] en, logic [3:0] fi);
    @(negedge clk);
    wr_sel_a = wa; chan_en = en; chan_fired = fi; shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    rd("R7", 1, 1, 8'h00); rd("R7", 1, 0, 8'h00);
    rd("R7", 0, 1, 8'h00); rd("R7", 0, 0, 8'h00);
    rst_n = 1'b1;
    // R1 layout: ch1 enable -> bit0, ch4 fired -> bit7
    pulse(1, 4'b0001, 4'b1000);
    rd("R1", 1, 1, 8'h81);
    rd("R6", 1, 0, 8'h00);
    rd("R2", 0, 1, 8'h00);
    // R4 shift into previous
    pulse(1, 4'b1100, 4'b0011);
    rd("R4", 1, 1, 8'h3C);
    rd("R4", 1, 0, 8'h81);
    // R2 load B, A untouched
    pulse(0, 4'b1010, 4'b0101);
    rd("R5", 0, 1, 8'h5A);
    rd("R2", 1, 1, 8'h3C);
    rd("R2", 1, 0, 8'h81);
    rd("R6", 0, 0, 8'h00);
    // R3 data changes without a strobe
    @(negedge clk); chan_en = 4'hF; chan_fired = 4'hF;
    repeat (3) @(negedge clk);
    rd("R3", 1, 1, 8'h3C);
    // R3 strobe held high while data changes: only the first word is taken
    @(negedge clk); wr_sel_a = 0; chan_en = 4'h7; chan_fired = 4'h1; shift_in = 1;
    @(negedge clk); chan_en = 4'h2; chan_fired = 4'h9;
    @(negedge clk); wr_sel_a = 1; chan_en = 4'h4;
    @(negedge clk); shift_in = 0;
    rd("R3", 0, 1, 8'h17);
    rd("R3", 0, 0, 8'h5A);
    rd("R3", 1, 1, 8'h3C);
    // R5 / R6 combinational switching
    rd("R5", 1, 0, 8'h81);
    rd("R5", 0, 0, 8'h5A);
    // R7 reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    rd("R7", 1, 1, 8'h00); rd("R7", 1, 0, 8'h00);
    rd("R7", 0, 1, 8'h00); rd("R7", 0, 0, 8'h00);
    pulse(0, 4'h9, 4'h6);
    rd("R8", 0, 1, 8'h69);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule